// File: doc/BRIEF.md
# Power Mode Control Register

This block is the 4-bit mode and status register of a system-basis-style power controller. A register-bus port, decoded by an SPI front end, addresses it. A write carries a 3-bit command. The command moves the device between Normal, Standby, Stop and Sleep, or it toggles a debug state in which no watchdog runs. A read at the same address returns four latched event flags: battery fail, regulator temperature pre-warning, general failure and watchdog reset. The read clears those flags.

Sleep is a guarded transition. The block accepts a Sleep command only when the battery-fail flag has already been cleared by a read and the no-stop bit of the reset-control register is set. The block drives the current mode, the debug state, a watchdog-enable level and a one-cycle pulse whenever an accepted command changes the mode. In Stop outside debug, the watchdog-enable level follows a bit of the reset-control register. Supply comparators, the watchdog timer and the serial link are outside the block. Their events arrive as input pulses.

Top module: `pwr_mode_reg`

## Requirements
- R1: While `rst` is high, and after it is released, the block holds mode Normal (`mode` = 2'b00), with `debug_on`=0, `wd_en`=1, `mode_chg`=0 and `rd_data`=0. All status flags are clear. Mode encoding: 00 Normal, 01 Standby, 10 Stop, 11 Sleep.
- R2: Outside debug, a write with `wr_data[2:0]` = 001, 010 or 011 selects Normal, Standby or Stop. The new mode is visible the cycle after the write. Codes 101, 110 and 111 are ignored outside debug.
- R3: Code 000 toggles `debug_on` and leaves `mode` unchanged.
- R4: In debug, codes 101, 110 and 111 select Normal, Standby and Stop. Codes 001 to 100 are ignored in debug.
- R5: `wd_en` is 0 in debug and in Sleep. Outside debug it is 1 in Normal and Standby. In Stop outside debug it equals `rcr_wd_stop`, one cycle delayed.
- R6: Code 100 outside debug enters Sleep only when the battery-fail flag is clear and `rcr_nostop` is 1. Otherwise the mode is unchanged.
- R7: Each event pulse sets its flag. A read (`rd_en`) places the flags on `rd_data` the next cycle, with D3 temperature, D2 general fail, D1 watchdog reset and D0 battery fail.
- R8: A read clears every flag it returns. An event arriving in the same cycle as the read keeps its flag set for the next read.
- R9: `wr_data[3]` has no effect on the mode. No write sets any status flag.
- R10: `mode_chg` is high for exactly one cycle after each accepted command that changes `mode`. It stays low for a debug toggle and for a refused or ignored command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data; bits 2..0 are the command |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 4 | Status returned one cycle after a read |
| evt_batfail | input | 1 | Supply below battery-fail threshold |
| evt_temp | input | 1 | Regulator temperature pre-warning |
| evt_fail | input | 1 | CAN fault, high-side overtemperature or low secondary supply |
| evt_wdrst | input | 1 | Watchdog reset happened |
| rcr_wd_stop | input | 1 | Reset-control bit: watchdog runs in Stop |
| rcr_nostop | input | 1 | Reset-control bit: no-stop flag, required for Sleep |
| mode | output | 2 | Current power mode |
| debug_on | output | 1 | Debug state active |
| wd_en | output | 1 | Watchdog enable |
| mode_chg | output | 1 | One-cycle pulse on an accepted mode change |

## Verification
The bench builds the block with its default widths: a 4-bit data path and a 4-flag status vector. At these widths every one of the eight command codes can be reached, both inside and outside debug. With all four flags present, the bit order on a read can be checked, along with a read that coincides with an event. Every combination of the two Sleep preconditions can also be reached.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_STANDBY = 2'd1,
    PM_STOP    = 2'd2,
    PM_SLEEP   = 2'd3
  } pm_mode_e;

  localparam int PM_CODE_W = 3;

  // status bit positions on a read
  localparam int ST_BAT  = 0;
  localparam int ST_WDR  = 1;
  localparam int ST_FAIL = 2;
  localparam int ST_TEMP = 3;
endpackage

// File: rtl/pmr_status.sv
module pmr_status #(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [STAT_W-1:0] evt,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] rd_data
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        stat_q[i] <= 1'b0;
      end else begin
        // a new event outranks the clear done by a read
        stat_q[i] <= evt[i] | (stat_q[i] & ~rd_en);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= stat_q;
  end
endmodule

// File: rtl/pmr_mode_ctl.sv
module pmr_mode_ctl
  import pmr_pkg::*;
#(
  parameter int CODE_W = PM_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] code,
  input  logic              bat_clear,
  input  logic              nostop,
  input  logic              wd_stop,
  output pm_mode_e          mode_q,
  output logic              dbg_q,
  output logic              wd_q,
  output logic              chg_q
);
  pm_mode_e mode_n;
  logic     dbg_n;
  logic     wd_n;
  logic     sleep_ok;

  assign sleep_ok = bat_clear & nostop;

  always_comb begin
    mode_n = mode_q;
    dbg_n  = dbg_q;
    if (wr_en) begin
      case (code)
        3'd0: dbg_n = ~dbg_q;
        3'd1: if (!dbg_q) mode_n = PM_NORMAL;
        3'd2: if (!dbg_q) mode_n = PM_STANDBY;
        3'd3: if (!dbg_q) mode_n = PM_STOP;
        3'd4: if (!dbg_q && sleep_ok) mode_n = PM_SLEEP;
        3'd5: if (dbg_q) mode_n = PM_NORMAL;
        3'd6: if (dbg_q) mode_n = PM_STANDBY;
        default: if (dbg_q) mode_n = PM_STOP;
      endcase
    end
  end

  always_comb begin
    if (dbg_n) begin
      wd_n = 1'b0;
    end else begin
      case (mode_n)
        PM_NORMAL, PM_STANDBY: wd_n = 1'b1;
        PM_STOP:               wd_n = wd_stop;
        default:               wd_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_NORMAL;
      dbg_q  <= 1'b0;
      wd_q   <= 1'b1;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      dbg_q  <= dbg_n;
      wd_q   <= wd_n;
      chg_q  <= (mode_n != mode_q);
    end
  end
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pmr_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [STAT_W-1:0] rd_data,
  input  logic              evt_batfail,
  input  logic              evt_temp,
  input  logic              evt_fail,
  input  logic              evt_wdrst,
  input  logic              rcr_wd_stop,
  input  logic              rcr_nostop,
  output logic [1:0]        mode,
  output logic              debug_on,
  output logic              wd_en,
  output logic              mode_chg
);
  localparam int CODE_W = PM_CODE_W;

  logic [STAT_W-1:0] evt_vec;
  logic [STAT_W-1:0] stat_q;
  pm_mode_e          mode_st;

  always_comb begin
    evt_vec          = '0;
    evt_vec[ST_BAT]  = evt_batfail;
    evt_vec[ST_WDR]  = evt_wdrst;
    evt_vec[ST_FAIL] = evt_fail;
    evt_vec[ST_TEMP] = evt_temp;
  end

  pmr_status #(.STAT_W(STAT_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .evt     (evt_vec),
    .stat_q  (stat_q),
    .rd_data (rd_data)
  );

  pmr_mode_ctl #(.CODE_W(CODE_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .code      (wr_data[CODE_W-1:0]),
    .bat_clear (~stat_q[ST_BAT]),
    .nostop    (rcr_nostop),
    .wd_stop   (rcr_wd_stop),
    .mode_q    (mode_st),
    .dbg_q     (debug_on),
    .wd_q      (wd_en),
    .chg_q     (mode_chg)
  );

  assign mode = mode_st;
endmodule

// File: rtl/pmr_chk.sv
module pmr_chk #(
  parameter int DATA_W = 4,
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              evt_temp,
  input logic              rcr_nostop,
  input logic [STAT_W-1:0] stat_q,
  input logic [1:0]        mode,
  input logic              debug_on,
  input logic              wd_en,
  input logic              mode_chg
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mode == 2'b00 && !debug_on && wd_en && !mode_chg && stat_q == '0));

  // R6
  sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[2:0] == 3'b100 && !debug_on && (stat_q[0] || !rcr_nostop))
      |=> $stable(mode));

  // R5
  debug_wd_off_chk: assert property (@(posedge clk) disable iff (rst)
    debug_on |-> !wd_en);

  // R5
  sleep_wd_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |-> !wd_en);

  // R8
  event_kept_chk: assert property (@(posedge clk) disable iff (rst)
    evt_temp |=> stat_q[3]);

  // R10
  chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !mode_chg);

  // R3
  debug_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[2:0] == 3'b000) |=> ($stable(mode) && debug_on != $past(debug_on)));
endmodule

bind pwr_mode_reg pmr_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .evt_temp   (evt_temp),
  .rcr_nostop (rcr_nostop),
  .stat_q     (stat_q),
  .mode       (mode),
  .debug_on   (debug_on),
  .wd_en      (wd_en),
  .mode_chg   (mode_chg)
);

// File: tb/pwr_mode_reg_tb.sv
`timescale 1ns/1ps
module pwr_mode_reg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_data;
  logic       evt_batfail = 1'b0, evt_temp = 1'b0, evt_fail = 1'b0, evt_wdrst = 1'b0;
  logic       rcr_wd_stop = 1'b0, rcr_nostop = 1'b0;
  logic [1:0] mode;
  logic       debug_on, wd_en, mode_chg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pwr_mode_reg u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .evt_batfail(evt_batfail), .evt_temp(evt_temp),
    .evt_fail(evt_fail), .evt_wdrst(evt_wdrst), .rcr_wd_stop(rcr_wd_stop),
    .rcr_nostop(rcr_nostop), .mode(mode), .debug_on(debug_on), .wd_en(wd_en),
    .mode_chg(mode_chg)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [3:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 debug", debug_on, 0);
    chk("R1 wd_en", wd_en, 1);
    chk("R1 chg", mode_chg, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_modes();
    cmd(4'b0010);
    chk("R2 standby", mode, 1);
    chk("R10 pulse", mode_chg, 1);
    @(negedge clk);
    chk("R10 pulse ends", mode_chg, 0);
    rcr_wd_stop = 1'b0;
    cmd(4'b0011);
    chk("R2 stop", mode, 2);
    chk("R5 stop wd off", wd_en, 0);
    rcr_wd_stop = 1'b1;
    @(negedge clk);
    chk("R5 stop wd follows", wd_en, 1);
    cmd(4'b0110);
    chk("R2 code110 ignored", mode, 2);
    chk("R10 no pulse ignored", mode_chg, 0);
    cmd(4'b0001);
    chk("R2 normal", mode, 0);
    chk("R5 normal wd", wd_en, 1);
  endtask

  task automatic t_status();
    logic [3:0] v;
    @(negedge clk); evt_temp = 1'b1; evt_fail = 1'b1;
    @(negedge clk); evt_temp = 1'b0; evt_fail = 1'b0;
    rd(v);
    chk("R7 order", v, 4'b1100);
    rd(v);
    chk("R8 cleared", v, 0);
    @(negedge clk); rd_en = 1'b1; evt_wdrst = 1'b1;
    @(negedge clk); rd_en = 1'b0; evt_wdrst = 1'b0;
    chk("R8 read same cycle old", rd_data, 0);
    rd(v);
    chk("R8 event wins", v, 4'b0010);
  endtask

  task automatic t_sleep();
    logic [3:0] v;
    @(negedge clk); evt_batfail = 1'b1;
    @(negedge clk); evt_batfail = 1'b0;
    rcr_nostop = 1'b1;
    cmd(4'b0100);
    chk("R6 refused batfail", mode, 0);
    chk("R10 no pulse refused", mode_chg, 0);
    rd(v);
    chk("R7 batfail bit", v, 4'b0001);
    rcr_nostop = 1'b0;
    cmd(4'b0100);
    chk("R6 refused nostop", mode, 0);
    rcr_nostop = 1'b1;
    cmd(4'b0100);
    chk("R6 sleep entered", mode, 3);
    chk("R5 sleep wd", wd_en, 0);
    cmd(4'b0001);
    chk("R2 wake normal", mode, 0);
  endtask

  task automatic t_debug();
    cmd(4'b0000);
    chk("R3 debug on", debug_on, 1);
    chk("R3 mode kept", mode, 0);
    chk("R10 no pulse toggle", mode_chg, 0);
    chk("R5 debug wd", wd_en, 0);
    cmd(4'b0110);
    chk("R4 dbg standby", mode, 1);
    cmd(4'b0011);
    chk("R4 code011 ignored", mode, 1);
    rcr_wd_stop = 1'b1;
    cmd(4'b0111);
    chk("R4 dbg stop", mode, 2);
    chk("R5 dbg stop wd", wd_en, 0);
    cmd(4'b0101);
    chk("R4 dbg normal", mode, 0);
    cmd(4'b0011);
    chk("R4 code011 still ignored", mode, 0);
    cmd(4'b0000);
    chk("R3 debug off", debug_on, 0);
    chk("R5 wd back", wd_en, 1);
  endtask

  task automatic t_d3();
    logic [3:0] v;
    cmd(4'b1010);
    chk("R9 d3 ignored", mode, 1);
    cmd(4'b1001);
    chk("R9 d3 ignored normal", mode, 0);
    rd(v);
    chk("R9 write sets no flag", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_modes();
    t_status();
    t_sleep();
    t_debug();
    t_d3();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule